// File: doc/BRIEF.md
# Phase-Correct PWM Timer with Input Capture

A 16-bit timer/counter for a microcontroller-class peripheral set. A clock selector feeds it from the system clock, from one of four taps of a free-running prescaler, or from an external pin. The pin is synchronised and edge-detected before use. Control fields arrive as plain inputs. Software-style write strobes preset the counter and the compare value, and the counter, the compare value and the capture register can be read at any time.

In normal mode the counter counts up and wraps. In one of three PWM modes it runs up and then down between zero and a TOP of 0x00FF, 0x01FF or 0x03FF. A compare value written in PWM mode is held in a buffer and only becomes active when the counter arrives at TOP, so every pulse on the compare output is whole and centred. A rising edge on the capture input copies the counter into the capture register. Three sticky flags report overflow, compare match and capture.

Top module: `pwm_capture_timer`

## Requirements
- R1: After a synchronous reset the counter, active and buffered compare values, capture register, all three flags and the output pin are zero, and the counting direction is up.
- R2: The mode input selects the counting: 00 normal, 01 up/down with TOP 0x00FF, 10 with TOP 0x01FF, 11 with TOP 0x03FF. In a PWM mode, a step taken at or above TOP goes to TOP-1 and turns downward, and a step taken at zero goes to 1 and turns upward.
- R3: In normal mode each timer tick adds one, 0xFFFF wraps to 0, and that wrap sets the overflow flag.
- R4: In a PWM mode the overflow flag sets on the tick that brings the counter to zero.
- R5: The clock select input picks the tick source: 0 stop, 1 every clock, 2 every 8th, 3 every 64th, 4 every 256th, 5 every 1024th clock of a free-running 10-bit prescaler, 6 falling and 7 rising edges of the external clock pin.
- R6: The external clock pin passes through two synchronising flip-flops and an edge detector, so each edge of the selected polarity gives exactly one tick.
- R7: A counter write takes priority over a tick in that cycle, and counting carries on from the written value at the next tick.
- R8: A rising edge on the capture input copies the counter value of that cycle into the capture register and sets the capture flag. A level held high does not capture again.
- R9: In PWM mode a compare write goes into a buffer that moves to the active compare value on the tick that brings the counter to TOP. In normal mode the write takes effect at once. The compare read port always shows the most recent write.
- R10: A compare match is a tick whose new counter value equals the active compare value, and it sets the compare flag. In PWM mode, output mode 10 (non-inverting) drives the pin low on a match while counting up and high on a match while counting down. Output mode 11 (inverting) does the opposite. Output modes 00 and 01 hold the pin low.
- R11: In PWM mode, when the active compare value is 0, a match drives the pin to its inactive level (low when non-inverting). When it equals TOP, a match drives the pin to its active level (high when non-inverting).
- R12: In normal mode a compare match toggles the pin under output mode 01, clears it under 10 and sets it under 11. Output mode 00 holds the pin low.
- R13: Each flag stays set until its flag_clr bit is pulsed (bit 0 overflow, bit 1 compare, bit 2 capture). A new event in the same cycle as a clear keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Counting and PWM resolution select |
| clk_sel | input | 3 | Tick source select |
| oc_mode | input | 2 | Compare output behaviour |
| ext_clk | input | 1 | External count source (asynchronous) |
| capt_in | input | 1 | Capture event input (rising edge) |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | 16 | Compare write value |
| flag_clr | input | 3 | Flag clear pulses |
| cnt_q | output | 16 | Current counter value |
| cmp_q | output | 16 | Most recently written compare value |
| cap_q | output | 16 | Capture register |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare match flag |
| cap_flag | output | 1 | Capture flag |
| oc_pin | output | 1 | Compare output pin |

## Verification
The assertions assume that capt_in, the write strobes and the control fields are synchronous to clk, and that a preset in PWM mode lies at or below TOP. Only ext_clk may change at arbitrary times. The stimulus drives every input on the falling clock edge, presets only in-range values and changes the mode only under reset. The step and bound properties therefore never meet a counter that was pushed above TOP.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int CW = 16;

    typedef enum logic [1:0] {
        PWM_OFF = 2'b00,
        PWM_8   = 2'b01,
        PWM_9   = 2'b10,
        PWM_10  = 2'b11
    } pwm_mode_e;

    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_CK       = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    typedef enum logic [1:0] {
        OC_OFF    = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_CLEAR  = 2'b10,
        OC_SET    = 2'b11
    } oc_mode_e;

    // Per-tick events from the counter, valid in the cycle before the edge
    typedef struct packed {
        logic ovf;       // wrap or arrival at zero
        logic hit;       // new value equals active compare
        logic rising;    // step direction of this tick
        logic cmp_zero;  // active compare is zero
        logic cmp_top;   // active compare is TOP
    } cnt_evt_t;

    function automatic logic [CW-1:0] top_of(pwm_mode_e m);
        case (m)
            PWM_8:   return CW'(16'h00FF);
            PWM_9:   return CW'(16'h01FF);
            PWM_10:  return CW'(16'h03FF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/ptc_clk_sel.sv
module ptc_clk_sel
    import ptc_pkg::*;
#(
    parameter int PRE_W = 10,
    parameter int SYNC_N = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    input  logic     ext_clk,
    output logic     tick
);
    localparam int TAP8   = 3;
    localparam int TAP64  = 6;
    localparam int TAP256 = 8;

    logic [PRE_W-1:0]  pre;
    logic [SYNC_N:0]   sync;   // SYNC_N synchronisers plus one edge-history stage
    logic              ext_rise, ext_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre  <= '0;
            sync <= '0;
        end else begin
            pre  <= pre + 1'b1;
            sync <= {sync[SYNC_N-1:0], ext_clk};
        end
    end

    // R6: edge detect behind the synchronisers
    assign ext_rise = sync[SYNC_N-1] & ~sync[SYNC_N];
    assign ext_fall = ~sync[SYNC_N-1] & sync[SYNC_N];

    // R5: tick source select
    always_comb begin
        case (sel)
            CS_CK:       tick = 1'b1;
            CS_DIV8:     tick = &pre[TAP8-1:0];
            CS_DIV64:    tick = &pre[TAP64-1:0];
            CS_DIV256:   tick = &pre[TAP256-1:0];
            CS_DIV1024:  tick = &pre;
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
            default:     tick = 1'b0;
        endcase
    end

    // R5: divided ticks are never back to back
    p_div8_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (sel == CS_DIV8 && tick) |=> !tick);

    // R6: an external edge tick is a single-cycle pulse
    p_ext_single_r6: assert property (@(posedge clk) disable iff (rst)
        (sel == CS_EXT_RISE && tick) |=> !ext_rise);

endmodule

// File: rtl/ptc_count.sv
module ptc_count
    import ptc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  pwm_mode_e      mode,
    input  logic           tick,
    input  logic           we,
    input  logic [CW-1:0]  wdata,
    input  logic           cmp_we,
    input  logic [CW-1:0]  cmp_wdata,
    output logic [CW-1:0]  cnt,
    output logic [CW-1:0]  ocr_buf,
    output logic [CW-1:0]  ocr_act,
    output cnt_evt_t       evt
);
    logic [CW-1:0] top, nxt;
    logic          pwm, dir_up, dir_n, step_up, adv;

    assign top = top_of(mode);
    assign pwm = (mode != PWM_OFF);
    assign adv = tick & ~we;           // R7: a write wins over a tick

    // R2/R3: next value and direction
    always_comb begin
        nxt     = cnt + 1'b1;
        dir_n   = 1'b1;
        step_up = 1'b1;
        if (pwm) begin
            if (dir_up) begin
                if (cnt >= top) begin
                    nxt     = top - 1'b1;
                    dir_n   = 1'b0;
                    step_up = 1'b0;
                end
            end else if (cnt == '0) begin
                nxt = CW'(1);
            end else begin
                nxt     = cnt - 1'b1;
                dir_n   = 1'b0;
                step_up = 1'b0;
            end
        end
    end

    always_comb begin
        evt.ovf      = adv & (pwm ? (nxt == '0) : (cnt == '1));   // R3/R4
        evt.hit      = adv & (nxt == ocr_act);                    // R10
        evt.rising   = step_up;
        evt.cmp_zero = (ocr_act == '0);
        evt.cmp_top  = (ocr_act == top);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            dir_up  <= 1'b1;
            ocr_buf <= '0;
            ocr_act <= '0;
        end else begin
            if (we) begin
                cnt <= wdata;
            end else if (tick) begin
                cnt    <= nxt;
                dir_up <= dir_n;
            end
            if (cmp_we)
                ocr_buf <= cmp_wdata;
            // R9: immediate in normal mode, latched at TOP in PWM mode
            if (cmp_we && !pwm)
                ocr_act <= cmp_wdata;
            else if (pwm && adv && nxt == top)
                ocr_act <= ocr_buf;
        end
    end

    // R2: in PWM mode each tick moves the counter by exactly one
    p_pwm_step_r2: assert property (@(posedge clk) disable iff (rst)
        (pwm && adv && cnt <= top) |=>
            (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

    // R2: an in-range PWM counter never exceeds TOP
    p_pwm_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (pwm && !we && cnt <= top) |=> (cnt <= $past(top)));

    // R5: without a tick or a write the counter holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !we) |=> $stable(cnt));

    // R9: in PWM mode the active compare changes only on arrival at TOP
    p_act_at_top_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) != PWM_OFF && ocr_act != $past(ocr_act)) |->
            (cnt == top_of($past(mode))));

endmodule

// File: rtl/ptc_oc.sv
module ptc_oc
    import ptc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwm,
    input  oc_mode_e oc_mode,
    input  cnt_evt_t evt,
    output logic     pin
);
    logic inv;
    logic off;

    assign inv = (oc_mode == OC_SET);
    assign off = (oc_mode == OC_OFF) || (pwm && oc_mode == OC_TOGGLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
        end else if (off) begin
            pin <= 1'b0;
        end else if (evt.hit) begin
            if (!pwm) begin
                // R12: normal-mode compare actions
                case (oc_mode)
                    OC_TOGGLE: pin <= ~pin;
                    OC_CLEAR:  pin <= 1'b0;
                    default:   pin <= 1'b1;
                endcase
            end else if (evt.cmp_zero) begin
                pin <= inv;                    // R11
            end else if (evt.cmp_top) begin
                pin <= ~inv;                   // R11
            end else begin
                pin <= evt.rising ? inv : ~inv; // R10
            end
        end
    end

    // R10: the pin moves only on a match or a change of setting
    p_pin_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!evt.hit && $stable(oc_mode) && $stable(pwm)) |=> $stable(pin));

endmodule

// File: rtl/pwm_capture_timer.sv
module pwm_capture_timer
    import ptc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode,
    input  logic [2:0]  clk_sel,
    input  logic [1:0]  oc_mode,
    input  logic        ext_clk,
    input  logic        capt_in,
    input  logic        cnt_we,
    input  logic [15:0] cnt_wdata,
    input  logic        cmp_we,
    input  logic [15:0] cmp_wdata,
    input  logic [2:0]  flag_clr,
    output logic [15:0] cnt_q,
    output logic [15:0] cmp_q,
    output logic [15:0] cap_q,
    output logic        ovf_flag,
    output logic        cmp_flag,
    output logic        cap_flag,
    output logic        oc_pin
);
    pwm_mode_e     mode_e;
    logic          tick, capt_prev, cap_ev;
    logic [CW-1:0] ocr_act;
    cnt_evt_t      evt;

    assign mode_e = pwm_mode_e'(mode);

    ptc_clk_sel #(.PRE_W(10), .SYNC_N(2)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .sel     (clk_sel_e'(clk_sel)),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    ptc_count u_cnt (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .tick      (tick),
        .we        (cnt_we),
        .wdata     (cnt_wdata),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .cnt       (cnt_q),
        .ocr_buf   (cmp_q),
        .ocr_act   (ocr_act),
        .evt       (evt)
    );

    ptc_oc u_oc (
        .clk     (clk),
        .rst     (rst),
        .pwm     (mode_e != PWM_OFF),
        .oc_mode (oc_mode_e'(oc_mode)),
        .evt     (evt),
        .pin     (oc_pin)
    );

    assign cap_ev = capt_in & ~capt_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            capt_prev <= 1'b0;
            cap_q     <= '0;
            ovf_flag  <= 1'b0;
            cmp_flag  <= 1'b0;
            cap_flag  <= 1'b0;
        end else begin
            capt_prev <= capt_in;
            if (cap_ev)
                cap_q <= cnt_q;                              // R8
            // R13: sticky, set wins over clear
            ovf_flag <= (ovf_flag & ~flag_clr[0]) | evt.ovf;
            cmp_flag <= (cmp_flag & ~flag_clr[1]) | evt.hit;
            cap_flag <= (cap_flag & ~flag_clr[2]) | cap_ev;
        end
    end

    // R8: a capture edge always leaves the capture flag set
    p_cap_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (capt_in && !capt_prev) |=> cap_flag);

    // R8: the capture register moves only on a capture edge
    p_cap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(capt_in && !capt_prev) |=> $stable(cap_q));

    // R13: a flag that is not cleared stays set
    p_ovf_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr[0]) |=> ovf_flag);

endmodule

// File: tb/pwm_capture_timer_bench.sv
module pwm_capture_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    // {mode[50:49], preload[48:33], ticks[32:17], expected count[16:1], expected overflow[0]}
    localparam logic [50:0] VEC [NV] = '{
        {2'b00, 16'hFFFE, 16'd3,   16'h0001, 1'b1},
        {2'b01, 16'd250,  16'd10,  16'd250,  1'b0},
        {2'b10, 16'd508,  16'd6,   16'd508,  1'b0},
        {2'b11, 16'd1022, 16'd4,   16'd1020, 1'b0},
        {2'b01, 16'd255,  16'd257, 16'd2,    1'b1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic [2:0]  clk_sel;
    logic [1:0]  oc_mode;
    logic        ext_clk, capt_in, cnt_we, cmp_we;
    logic [15:0] cnt_wdata, cmp_wdata;
    logic [2:0]  flag_clr;
    logic [15:0] cnt_q, cmp_q, cap_q;
    logic        ovf_flag, cmp_flag, cap_flag, oc_pin;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_capture_timer u_pwm_capture_timer (
        .clk(clk), .rst(rst), .mode(mode), .clk_sel(clk_sel), .oc_mode(oc_mode),
        .ext_clk(ext_clk), .capt_in(capt_in), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .flag_clr(flag_clr),
        .cnt_q(cnt_q), .cmp_q(cmp_q), .cap_q(cap_q), .ovf_flag(ovf_flag),
        .cmp_flag(cmp_flag), .cap_flag(cap_flag), .oc_pin(oc_pin)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; mode = m; clk_sel = 3'd0; oc_mode = 2'b00; ext_clk = 1'b0;
        capt_in = 1'b0; cnt_we = 1'b0; cmp_we = 1'b0; cnt_wdata = '0; cmp_wdata = '0;
        flag_clr = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic wr_cmp(input logic [15:0] v);
        cmp_we = 1'b1; cmp_wdata = v;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    task automatic run(input int n);
        clk_sel = 3'd1;
        repeat (n) @(negedge clk);
        clk_sel = 3'd0;
    endtask

    task automatic run_sel(input logic [2:0] s, input int n);
        clk_sel = s;
        repeat (n) @(negedge clk);
        clk_sel = 3'd0;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(2'b00);
        chk("R1 cnt", cnt_q, 0);
        chk("R1 cmp", cmp_q, 0);
        chk("R1 cap", cap_q, 0);
        chk("R1 flags", {ovf_flag, cmp_flag, cap_flag}, 0);
        chk("R1 pin", oc_pin, 0);

        // R2/R3/R4: counting vectors
        for (int i = 0; i < NV; i++) begin
            do_reset(VEC[i][50:49]);
            wr_cnt(VEC[i][48:33]);
            run(int'(VEC[i][32:17]));
            chk(VEC[i][50:49] == 2'b00 ? "R3 count" : "R2 count", cnt_q, int'(VEC[i][16:1]));
            chk(VEC[i][50:49] == 2'b00 ? "R3 ovf" : "R4 ovf", ovf_flag, int'(VEC[i][0]));
        end

        // R5: prescaler taps
        do_reset(2'b00);
        run_sel(3'd2, 64);   chk("R5 div8", cnt_q, 8);
        wr_cnt(0); run_sel(3'd3, 128);  chk("R5 div64", cnt_q, 2);
        wr_cnt(0); run_sel(3'd4, 512);  chk("R5 div256", cnt_q, 2);
        wr_cnt(0); run_sel(3'd5, 2048); chk("R5 div1024", cnt_q, 2);
        wr_cnt(0); run_sel(3'd0, 20);   chk("R5 stop", cnt_q, 0);

        // R6: external edges
        wr_cnt(0); clk_sel = 3'd7; ext_pulses(3); clk_sel = 3'd0;
        chk("R6 rising", cnt_q, 3);
        wr_cnt(0); clk_sel = 3'd6; ext_pulses(3); clk_sel = 3'd0;
        chk("R6 falling", cnt_q, 3);

        // R7: write while running
        wr_cnt(0);
        clk_sel = 3'd1;
        repeat (3) @(negedge clk);
        chk("R7 pre", cnt_q, 3);
        cnt_we = 1'b1; cnt_wdata = 16'h0100;
        @(negedge clk);
        cnt_we = 1'b0;
        chk("R7 written", cnt_q, 16'h0100);
        @(negedge clk);
        clk_sel = 3'd0;
        chk("R7 resumed", cnt_q, 16'h0101);

        // R8/R13: capture and flag handling
        do_reset(2'b00);
        wr_cnt(16'h1234);
        capt_in = 1'b1;
        @(negedge clk);
        chk("R8 cap value", cap_q, 16'h1234);
        chk("R8 cap flag", cap_flag, 1);
        wr_cnt(16'h0055);
        @(negedge clk);
        chk("R8 level no recapture", cap_q, 16'h1234);
        capt_in = 1'b0;
        @(negedge clk);
        capt_in = 1'b1; flag_clr = 3'b100;
        @(negedge clk);
        capt_in = 1'b0; flag_clr = 3'b000;
        chk("R13 set wins", cap_flag, 1);
        chk("R8 second capture", cap_q, 16'h0055);
        flag_clr = 3'b100;
        @(negedge clk);
        flag_clr = 3'b000;
        chk("R13 cleared", cap_flag, 0);

        // R12: normal-mode compare output
        do_reset(2'b00);
        oc_mode = 2'b01;
        wr_cmp(5);
        run(5);
        chk("R12 toggle", oc_pin, 1);
        chk("R10 cmp flag", cmp_flag, 1);
        oc_mode = 2'b10; wr_cnt(4); run(1);
        chk("R12 clear", oc_pin, 0);
        oc_mode = 2'b11; wr_cnt(4); run(1);
        chk("R12 set", oc_pin, 1);

        // R9/R10: buffered compare, non-inverting
        do_reset(2'b01);
        oc_mode = 2'b10;
        wr_cmp(100);
        chk("R9 readback", cmp_q, 100);
        wr_cnt(254); run(1);
        wr_cmp(200);
        chk("R9 readback new", cmp_q, 200);
        run(55);
        chk("R9 old value holds", oc_pin, 0);
        run(100);
        chk("R10 down match high", oc_pin, 1);
        run(200);
        chk("R10 up match low", oc_pin, 0);
        chk("R4 bottom ovf", ovf_flag, 1);
        run(155); run(55);
        chk("R9 new value at TOP", oc_pin, 1);
        chk("R9 count", cnt_q, 200);

        // R10: inverting
        do_reset(2'b01);
        oc_mode = 2'b11;
        wr_cmp(100); wr_cnt(254); run(1);
        run(155); run(200);
        chk("R10 inverting up high", oc_pin, 1);

        // R11: forced extremes
        do_reset(2'b01);
        oc_mode = 2'b10;
        wr_cmp(255); wr_cnt(254); run(1);
        wr_cmp(0);
        run(510);
        chk("R11 top forces high", oc_pin, 1);
        chk("R11 at top", cnt_q, 255);
        run(255);
        chk("R11 zero forces low", oc_pin, 0);
        chk("R11 at bottom", cnt_q, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule